// File: doc/BRIEF.md
# Binary64 Floating-Point Subtractor

The block computes `x - y` for two IEEE 754 binary64 operands and returns a binary64 result with four exception flags. Each operand is sorted into one of six classes: signalling NaN, quiet NaN, zero, denormal, normal or infinity. A priority table that looks at both classes together settles NaNs, infinities and zeros. Every other pair goes through a sign-magnitude adder. The adder inverts the sign of `y`, aligns the smaller operand with guard, round and sticky bits, adds or subtracts the magnitudes, normalises the result and rounds it under a 2-bit rounding mode.

There is one output register. A valid/ready handshake sits on each side, so the block accepts one operation per cycle unless its output is stalled. Results leave in the order the operations were accepted.

Top module: `fpsub_top`

## Requirements
- R1: A signalling NaN (exponent all ones, fraction MSB 0, fraction non-zero) in `x` wins over every class of `y`. Otherwise a signalling NaN in `y` wins over every class of `x`. The winner is returned with its fraction MSB set and its sign unchanged. Invalid is raised: flags bit 3.
- R2: If neither operand is a signalling NaN, a quiet NaN (fraction MSB 1) is returned bit-for-bit with no flags. `x` wins when both operands are quiet NaNs, and a quiet NaN also wins over infinity.
- R3: Two infinities of equal sign return the default NaN 0x7FF8000000000000 and raise invalid. Opposite-sign infinities return `x`. An infinite `x` with a finite `y` returns `x`. A finite `x` with an infinite `y` returns infinity with the sign of `y` inverted. No other flag is raised in these cases.
- R4: When `y` is zero and `x` is finite non-zero, the result is `x`. When `x` is zero and `y` is finite non-zero, the result is `y` with its sign inverted. When both are zero and `x` has the sign opposite to `y`, the result is zero with the sign of `x`. All of these raise no flags.
- R5: Rounding mode `rm_i` is coded 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf. Two zeros of equal sign, and any exact cancellation of equal finite values, return +0 in every mode except 11, which returns -0.
- R6: Exactly representable differences are returned exactly with no flags, including sums whose magnitude carries into a higher exponent.
- R7: Inexact results are rounded by the selected mode and raise inexact: flags bit 0.
- R8: In nearest-even mode an exact halfway case rounds to the neighbour with an even last fraction bit.
- R9: When the rounded exponent reaches all ones, overflow (flags bit 2) and inexact are raised. The result is infinity in nearest-even mode and in the directed mode that rounds away from zero for that sign. Otherwise it is the largest finite value of that sign.
- R10: Denormal operands take part in arithmetic with full precision, and results below the normal range are encoded as denormals. Underflow (flags bit 1) is raised only for a tiny result that is also inexact. A subtraction result is never both, so the flag stays clear.
- R11: `in_ready_o` is high when the output register is empty or is being emptied in the same cycle. An accepted operation appears on the output the next cycle. A stalled output keeps its value.
- R12: After reset, `out_valid_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Operation can be taken this cycle |
| x_i | input | 64 | Minuend, binary64 |
| y_i | input | 64 | Subtrahend, binary64 |
| rm_i | input | 2 | Rounding mode |
| out_valid_o | output | 1 | Result held on the output |
| out_ready_i | input | 1 | Consumer takes the result |
| res_o | output | 64 | Result, binary64 |
| flags_o | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
The assertions assume the consumer follows the handshake. They also assume `in_valid_i` and the operand inputs are known at every clock edge after reset, because the output register loads them whenever `in_ready_o` is high. The stimulus drives every input on the falling edge and holds the offered operation until a rising edge at which `in_ready_o` is high. The consumer's ready follows a fixed irregular pattern, so stalls of varying length fall between results. Operands are chosen so that every class pair, every rounding direction and the overflow and denormal boundaries are reached.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO, CLS_DENORM, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
  } cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00, RM_ZERO = 2'b01, RM_UP = 2'b10, RM_DOWN = 2'b11
  } rmode_e;

  localparam int FLG_INV = 3;
  localparam int FLG_OVF = 2;
  localparam int FLG_UNF = 1;
  localparam int FLG_INX = 0;
endpackage

// File: rtl/fpsub_class.sv
module fpsub_class
  import fpsub_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output cls_e              cls_o
);
  logic exp_max, exp_min, frac_nz;
  assign exp_max = &exp_i;
  assign exp_min = ~|exp_i;
  assign frac_nz = |frac_i;

  always_comb begin
    if (exp_max)      cls_o = !frac_nz ? CLS_INF : (frac_i[FRAC_W-1] ? CLS_QNAN : CLS_SNAN);
    else if (exp_min) cls_o = frac_nz ? CLS_DENORM : CLS_ZERO;
    else              cls_o = CLS_NORM;
  end
endmodule

// File: rtl/fpsub_align_add.sv
module fpsub_align_add #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int MW    = FRAC_W + 1,
  localparam int XW    = MW + 3,
  localparam int EW    = EXP_W + 2
) (
  input  logic              xs_i,
  input  logic [EXP_W-1:0]  xe_i,
  input  logic [FRAC_W-1:0] xf_i,
  input  logic              ys_i,   // already inverted
  input  logic [EXP_W-1:0]  ye_i,
  input  logic [FRAC_W-1:0] yf_i,
  output logic              sign_o,
  output logic [EW-1:0]     exp_o,
  output logic [XW:0]       sum_o
);
  localparam logic [EXP_W-1:0] XW_E = EXP_W'(XW);

  logic [EXP_W-1:0] xe_eff, ye_eff, ea, eb, diff;
  logic [MW-1:0]    xm, ym, ma, mb;
  logic             sa, sb, x_big;
  logic [XW-1:0]    a_ext, b_ext, b_sh, b_al;
  logic             sticky;

  // denormals: exponent 1, no hidden bit
  assign xe_eff = (xe_i == '0) ? EXP_W'(1) : xe_i;
  assign ye_eff = (ye_i == '0) ? EXP_W'(1) : ye_i;
  assign xm     = {xe_i != '0, xf_i};
  assign ym     = {ye_i != '0, yf_i};
  assign x_big  = {xe_eff, xm} >= {ye_eff, ym};

  assign ea   = x_big ? xe_eff : ye_eff;
  assign eb   = x_big ? ye_eff : xe_eff;
  assign ma   = x_big ? xm : ym;
  assign mb   = x_big ? ym : xm;
  assign sa   = x_big ? xs_i : ys_i;
  assign sb   = x_big ? ys_i : xs_i;
  assign diff = ea - eb;

  assign a_ext = {ma, 3'b000};
  assign b_ext = {mb, 3'b000};

  always_comb begin
    if (diff >= XW_E) begin
      b_sh   = '0;
      sticky = |b_ext;
    end else begin
      b_sh   = b_ext >> diff;
      sticky = |(b_ext & ~({XW{1'b1}} << diff));
    end
  end
  assign b_al = {b_sh[XW-1:1], b_sh[0] | sticky};

  assign sum_o  = (sa ^ sb) ? ({1'b0, a_ext} - {1'b0, b_al})
                            : ({1'b0, a_ext} + {1'b0, b_al});
  assign sign_o = sa;
  assign exp_o  = {2'b00, ea};
endmodule

// File: rtl/fpsub_norm_round.sv
module fpsub_norm_round
  import fpsub_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int MW    = FRAC_W + 1,
  localparam int XW    = MW + 3,
  localparam int EW    = EXP_W + 2,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic          sign_i,
  input  logic [EW-1:0] exp_i,
  input  logic [XW:0]   sum_i,
  input  rmode_e        rm_i,
  output logic [W-1:0]  res_o,
  output logic [3:0]    flags_o
);
  localparam logic [EW-1:0] EXP_TOP = EW'((1 << EXP_W) - 1);

  function automatic logic [EW-1:0] lead_zeros(input logic [XW-1:0] v);
    lead_zeros = EW'(XW);
    for (int i = 0; i < XW; i++)
      if (v[i]) lead_zeros = EW'(XW - 1 - i);
  endfunction

  logic [EW-1:0] lz, sh, e1, e2;
  logic [XW-1:0] m1;
  logic          tiny, lsb, grd, rst, inx, inc, ovf, to_inf;
  logic [MW:0]   mant;
  logic [MW-1:0] mf;

  assign lz = lead_zeros(sum_i[XW-1:0]);
  // never drop below the denormal exponent
  assign sh = (lz < exp_i - EW'(1)) ? lz : exp_i - EW'(1);

  always_comb begin
    if (sum_i[XW]) begin
      m1 = {sum_i[XW:2], sum_i[1] | sum_i[0]};
      e1 = exp_i + EW'(1);
    end else begin
      m1 = sum_i[XW-1:0] << sh;
      e1 = exp_i - sh;
    end
  end

  assign tiny = !m1[XW-1];
  assign lsb  = m1[3];
  assign grd  = m1[2];
  assign rst  = m1[1] | m1[0];
  assign inx  = grd | rst;

  always_comb begin
    unique case (rm_i)
      RM_NEAR: inc = grd & (rst | lsb);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = inx & !sign_i;
      RM_DOWN: inc = inx & sign_i;
      default: inc = 1'b0;
    endcase
  end

  assign mant = {1'b0, m1[XW-1:3]} + {{MW{1'b0}}, inc};
  assign mf   = mant[MW] ? mant[MW:1] : mant[MW-1:0];
  assign e2   = mant[MW] ? e1 + EW'(1) : e1;
  assign ovf  = e2 >= EXP_TOP;
  assign to_inf = (rm_i == RM_NEAR) || (rm_i == RM_UP && !sign_i) ||
                  (rm_i == RM_DOWN && sign_i);

  always_comb begin
    flags_o = '0;
    if (sum_i == '0) begin
      res_o = {rm_i == RM_DOWN, {(W-1){1'b0}}};
    end else if (ovf) begin
      res_o = to_inf ? {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                     : {sign_i, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      flags_o[FLG_OVF] = 1'b1;
      flags_o[FLG_INX] = 1'b1;
    end else begin
      res_o = {sign_i, mf[MW-1] ? e2[EXP_W-1:0] : {EXP_W{1'b0}}, mf[FRAC_W-1:0]};
      flags_o[FLG_INX] = inx;
      flags_o[FLG_UNF] = tiny & inx;
    end
  end
endmodule

// File: rtl/fpsub_top.sv
module fpsub_top
  import fpsub_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int MW    = FRAC_W + 1,
  localparam int XW    = MW + 3,
  localparam int EW    = EXP_W + 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [1:0]   rm_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] res_o,
  output logic [3:0]   flags_o
);
  localparam logic [W-1:0] QUIET_BIT = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] DEF_NAN   = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] ops [2];
  cls_e         cls [2];
  rmode_e       rm;
  logic         ys_n;

  assign ops[0] = x_i;
  assign ops[1] = y_i;
  assign rm     = rmode_e'(rm_i);
  assign ys_n   = ~y_i[W-1];

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpsub_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_class (
      .exp_i  (ops[g][W-2:FRAC_W]),
      .frac_i (ops[g][FRAC_W-1:0]),
      .cls_o  (cls[g])
    );
  end

  logic          al_sign;
  logic [EW-1:0] al_exp;
  logic [XW:0]   al_sum;
  logic [W-1:0]  ar_res;
  logic [3:0]    ar_flags;

  fpsub_align_add #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_align_add (
    .xs_i   (x_i[W-1]),
    .xe_i   (x_i[W-2:FRAC_W]),
    .xf_i   (x_i[FRAC_W-1:0]),
    .ys_i   (ys_n),
    .ye_i   (y_i[W-2:FRAC_W]),
    .yf_i   (y_i[FRAC_W-1:0]),
    .sign_o (al_sign),
    .exp_o  (al_exp),
    .sum_o  (al_sum)
  );

  fpsub_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_norm_round (
    .sign_i  (al_sign),
    .exp_i   (al_exp),
    .sum_i   (al_sum),
    .rm_i    (rm),
    .res_o   (ar_res),
    .flags_o (ar_flags)
  );

  logic [W-1:0] res_n;
  logic [3:0]   flg_n;

  // class-pair priority table
  always_comb begin
    res_n = ar_res;
    flg_n = '0;
    if (cls[0] == CLS_SNAN) begin
      res_n = x_i | QUIET_BIT;
      flg_n[FLG_INV] = 1'b1;
    end else if (cls[1] == CLS_SNAN) begin
      res_n = y_i | QUIET_BIT;
      flg_n[FLG_INV] = 1'b1;
    end else if (cls[0] == CLS_QNAN) begin
      res_n = x_i;
    end else if (cls[1] == CLS_QNAN) begin
      res_n = y_i;
    end else if (cls[0] == CLS_INF && cls[1] == CLS_INF) begin
      if (x_i[W-1] == y_i[W-1]) begin
        res_n = DEF_NAN;
        flg_n[FLG_INV] = 1'b1;
      end else begin
        res_n = x_i;
      end
    end else if (cls[0] == CLS_INF) begin
      res_n = x_i;
    end else if (cls[1] == CLS_INF) begin
      res_n = {ys_n, y_i[W-2:0]};
    end else if (cls[0] == CLS_ZERO && cls[1] == CLS_ZERO) begin
      res_n = {(x_i[W-1] == ys_n) ? x_i[W-1] : (rm == RM_DOWN), {(W-1){1'b0}}};
    end else if (cls[1] == CLS_ZERO) begin
      res_n = x_i;
    end else if (cls[0] == CLS_ZERO) begin
      res_n = {ys_n, y_i[W-2:0]};
    end else begin
      flg_n = ar_flags;
    end
  end

  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_o       <= '0;
      flags_o     <= '0;
    end else begin
      if (in_ready_o) out_valid_o <= in_valid_i;
      if (in_valid_i && in_ready_o) begin
        res_o   <= res_n;
        flags_o <= flg_n;
      end
    end
  end
endmodule

// File: rtl/fpsub_chk.sv
module fpsub_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] res_o,
  input logic [3:0]   flags_o
);
  a_r11_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_o) && $stable(flags_o));

  a_r11_accept_shows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  a_r11_no_take_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  a_r1_invalid_gives_qnan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && flags_o[3] |-> &res_o[W-2:FRAC_W-1]);

  a_r9_overflow_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && flags_o[2] |-> flags_o[0]);
endmodule

bind fpsub_top fpsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_fpsub_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .res_o       (res_o),
  .flags_o     (flags_o)
);

// File: tb/test_fpsub_top.sv
module test_fpsub_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] x_in = '0, y_in = '0;
  logic [1:0]  rm_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] res;
  logic [3:0]  flags;

  always #5 clk = ~clk;

  fpsub_top i_fpsub_top (
    .clk_i (clk), .rst_ni (rst_n), .in_valid_i (in_valid), .in_ready_o (in_ready),
    .x_i (x_in), .y_i (y_in), .rm_i (rm_in), .out_valid_o (out_valid),
    .out_ready_i (out_ready), .res_o (res), .flags_o (flags)
  );

  int errors = 0, checks = 0, sent = 0, got = 0;
  bit done = 0;
  logic [63:0] exp_q [$];
  logic [3:0]  flg_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] x, input logic [63:0] y, input logic [1:0] rm,
                      input logic [63:0] er, input logic [3:0] ef, input string tag);
    @(negedge clk);
    in_valid = 1'b1; x_in = x; y_in = y; rm_in = rm;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(er); flg_q.push_back(ef); tag_q.push_back(tag);
    sent++;
    @(posedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    int cyc = 0;
    bit stalled = 0;
    logic [67:0] prev = '0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 3);
      #1;
      if (stalled)
        check(out_valid && {flags, res} == prev, "R11 stall hold", {flags, res}, prev);
      stalled = out_valid && !out_ready;
      prev = {flags, res};
      if (stalled) check(!in_ready, "R11 ready low when full", {67'b0, in_ready}, 68'b0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11 unexpected result", {flags, res}, 68'b0);
        end else begin
          logic [63:0] er;
          logic [3:0]  ef;
          string       t;
          er = exp_q.pop_front(); ef = flg_q.pop_front(); t = tag_q.pop_front();
          check({flags, res} == {ef, er}, t, {flags, res}, {ef, er});
          got++;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d results", got, sent);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid, "R12 reset valid", {67'b0, out_valid}, 68'b0);
    check(in_ready, "R12 reset ready", {67'b0, in_ready}, 68'b1);
    rst_n = 1'b1;

    // R6 exact
    send(64'h4008000000000000, 64'h3FF0000000000000, 2'd0, 64'h4000000000000000, 4'h0, "R6 3-1");
    send(64'h3FF0000000000000, 64'h4008000000000000, 2'd0, 64'hC000000000000000, 4'h0, "R6 1-3");
    send(64'h3FF0000000000000, 64'hBFF0000000000000, 2'd0, 64'h4000000000000000, 4'h0, "R6 carry");
    // R5 cancellation
    send(64'h3FF0000000000000, 64'h3FF0000000000000, 2'd0, 64'h0000000000000000, 4'h0, "R5 cancel near");
    send(64'h3FF0000000000000, 64'h3FF0000000000000, 2'd3, 64'h8000000000000000, 4'h0, "R5 cancel down");
    send(64'h3FF0000000000000, 64'h3FF0000000000000, 2'd2, 64'h0000000000000000, 4'h0, "R5 cancel up");
    send(64'h0000000000000000, 64'h0000000000000000, 2'd0, 64'h0000000000000000, 4'h0, "R5 zeros near");
    send(64'h0000000000000000, 64'h0000000000000000, 2'd3, 64'h8000000000000000, 4'h0, "R5 zeros down");
    // R4 zero operands
    send(64'h0000000000000000, 64'h8000000000000000, 2'd3, 64'h0000000000000000, 4'h0, "R4 +0 - -0");
    send(64'h8000000000000000, 64'h0000000000000000, 2'd0, 64'h8000000000000000, 4'h0, "R4 -0 - +0");
    send(64'h4014000000000000, 64'h0000000000000000, 2'd0, 64'h4014000000000000, 4'h0, "R4 x-0");
    send(64'h0000000000000000, 64'h4014000000000000, 2'd0, 64'hC014000000000000, 4'h0, "R4 0-y");
    send(64'h0000000000000001, 64'h0000000000000000, 2'd1, 64'h0000000000000001, 4'h0, "R4 denorm-0");
    // R1 signalling NaN
    send(64'h7FF0000000000001, 64'h3FF0000000000000, 2'd0, 64'h7FF8000000000001, 4'h8, "R1 snan x");
    send(64'h3FF0000000000000, 64'hFFF0000000000002, 2'd0, 64'hFFF8000000000002, 4'h8, "R1 snan y");
    send(64'h7FF0000000000001, 64'hFFF0000000000002, 2'd0, 64'h7FF8000000000001, 4'h8, "R1 both snan");
    send(64'h7FF8000000000005, 64'h7FF0000000000003, 2'd0, 64'h7FF8000000000003, 4'h8, "R1 snan over qnan");
    // R2 quiet NaN
    send(64'h7FF8000000000005, 64'h7FF800000000000A, 2'd0, 64'h7FF8000000000005, 4'h0, "R2 both qnan");
    send(64'h3FF0000000000000, 64'hFFF8000000000007, 2'd0, 64'hFFF8000000000007, 4'h0, "R2 qnan y");
    send(64'h7FF8000000000005, 64'h7FF0000000000000, 2'd0, 64'h7FF8000000000005, 4'h0, "R2 qnan vs inf");
    // R3 infinities
    send(64'h7FF0000000000000, 64'h7FF0000000000000, 2'd0, 64'h7FF8000000000000, 4'h8, "R3 inf-inf");
    send(64'hFFF0000000000000, 64'hFFF0000000000000, 2'd2, 64'h7FF8000000000000, 4'h8, "R3 -inf - -inf");
    send(64'h7FF0000000000000, 64'hFFF0000000000000, 2'd0, 64'h7FF0000000000000, 4'h0, "R3 inf - -inf");
    send(64'h3FF0000000000000, 64'h7FF0000000000000, 2'd0, 64'hFFF0000000000000, 4'h0, "R3 fin-inf");
    send(64'hFFF0000000000000, 64'h3FF0000000000000, 2'd0, 64'hFFF0000000000000, 4'h0, "R3 inf-fin");
    send(64'h0000000000000000, 64'hFFF0000000000000, 2'd0, 64'h7FF0000000000000, 4'h0, "R3 0 - -inf");
    // R7 rounding modes
    send(64'h3FF0000000000000, 64'h3C30000000000000, 2'd0, 64'h3FF0000000000000, 4'h1, "R7 sub near");
    send(64'h3FF0000000000000, 64'h3C30000000000000, 2'd1, 64'h3FEFFFFFFFFFFFFF, 4'h1, "R7 sub zero");
    send(64'h3FF0000000000000, 64'h3C30000000000000, 2'd3, 64'h3FEFFFFFFFFFFFFF, 4'h1, "R7 sub down");
    send(64'h3FF0000000000000, 64'h3C30000000000000, 2'd2, 64'h3FF0000000000000, 4'h1, "R7 sub up");
    send(64'h3FF0000000000000, 64'hBC30000000000000, 2'd0, 64'h3FF0000000000000, 4'h1, "R7 add near");
    send(64'h3FF0000000000000, 64'hBC30000000000000, 2'd2, 64'h3FF0000000000001, 4'h1, "R7 add up");
    send(64'h3FF0000000000000, 64'hBC30000000000000, 2'd1, 64'h3FF0000000000000, 4'h1, "R7 add zero");
    send(64'hBFF0000000000000, 64'h3C30000000000000, 2'd3, 64'hBFF0000000000001, 4'h1, "R7 neg down");
    send(64'hBFF0000000000000, 64'h3C30000000000000, 2'd2, 64'hBFF0000000000000, 4'h1, "R7 neg up");
    // R8 ties
    send(64'h3FF0000000000000, 64'hBCA0000000000000, 2'd0, 64'h3FF0000000000000, 4'h1, "R8 tie even down");
    send(64'h3FF0000000000001, 64'hBCA0000000000000, 2'd0, 64'h3FF0000000000002, 4'h1, "R8 tie odd up");
    // R9 overflow
    send(64'h7FEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 2'd0, 64'h7FF0000000000000, 4'h5, "R9 near inf");
    send(64'h7FEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 2'd1, 64'h7FEFFFFFFFFFFFFF, 4'h5, "R9 zero max");
    send(64'h7FEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 2'd2, 64'h7FF0000000000000, 4'h5, "R9 up inf");
    send(64'hFFEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 2'd2, 64'hFFEFFFFFFFFFFFFF, 4'h5, "R9 neg up max");
    send(64'hFFEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF, 2'd3, 64'hFFF0000000000000, 4'h5, "R9 neg down inf");
    // R10 denormals
    send(64'h0000000000000003, 64'h0000000000000001, 2'd0, 64'h0000000000000002, 4'h0, "R10 den-den");
    send(64'h0000000000000001, 64'h0000000000000003, 2'd0, 64'h8000000000000002, 4'h0, "R10 den neg");
    send(64'h0010000000000000, 64'h0000000000000001, 2'd0, 64'h000FFFFFFFFFFFFF, 4'h0, "R10 min normal - den");
    send(64'h0008000000000000, 64'h8008000000000000, 2'd0, 64'h0010000000000000, 4'h0, "R10 den to normal");
    @(negedge clk);
    in_valid = 1'b0;

    wait (got == sent);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule